// File: doc/BRIEF.md
# Power-Down Mode Controller

This block governs the low-power behaviour of a small processor core. A byte-wide control register holds a mode-select bit and a three-bit stabilization code. When the core executes its sleep instruction it pulses `sleep_req`. The controller then either halts the CPU with the main oscillator still running (sleep), or halts the CPU and stops the main oscillator (standby). The mode-select bit makes that choice.

Any asserted wake interrupt ends a low-power mode. From sleep the core resumes on the next cycle. From standby the controller first restarts the main oscillator. It keeps the system on the on-chip oscillator while a single stabilization timer counts the programmed number of wait states, and only then selects the main clock and releases the CPU. Software can also ask to move from the on-chip clock to the external clock with `clk_switch_req`. That switch uses the same timer and the same programmed wait, but the CPU keeps running on the internal clock while it waits. The whole controller runs on the always-running on-chip oscillator clock.

States: ACTIVE, SLEEP, STANDBY, WAIT_WAKE (stabilizing after standby, CPU halted) and WAIT_SWITCH (stabilizing for a software clock switch, CPU running). Transitions:
- ACTIVE→SLEEP on `sleep_req` when the mode bit is 0.
- ACTIVE→STANDBY on `sleep_req` when the mode bit is 1.
- ACTIVE→WAIT_SWITCH on `clk_switch_req` while the internal clock is selected.
- SLEEP→ACTIVE on any wake interrupt.
- STANDBY→WAIT_WAKE on any wake interrupt.
- WAIT_WAKE→ACTIVE and WAIT_SWITCH→ACTIVE on the timer's terminal count.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset `reg_rdata` is 0x00, `mode_o` is ACTIVE (encoding 0), `cpu_halt` is 0, `osc_en` is 1 and `clk_sel_ext` is 0.
- R2: A write takes effect on the next cycle. `reg_rdata[7]` is the standby-select bit and `reg_rdata[6:4]` is the stabilization code. `reg_rdata[3:0]` always reads 0, and write data in bits 3:0 is discarded.
- R3: `sleep_req` in ACTIVE with bit 7 clear moves to SLEEP (`mode_o` = 1) on the next cycle. In SLEEP `cpu_halt` is 1 and `osc_en` is 1.
- R4: In SLEEP, any set bit of `wake_irq` returns the controller to ACTIVE on the next cycle with no stabilization wait. `clk_sel_ext` keeps its value.
- R5: `sleep_req` in ACTIVE with bit 7 set moves to STANDBY (`mode_o` = 2). In STANDBY `cpu_halt` is 1, `osc_en` is 0 and `clk_sel_ext` is 0.
- R6: A wake interrupt in STANDBY enters the waiting mode (`mode_o` = 3) with `osc_en` 1, `cpu_halt` 1 and `clk_sel_ext` 0. The controller stays there for exactly 2^E cycles, where E = MAX_EXP − (code·(MAX_EXP−MIN_EXP))/7 (integer division), so code 0 is longest and code 7 is shortest. It then enters ACTIVE with `clk_sel_ext` 1.
- R7: `clk_switch_req` in ACTIVE while `clk_sel_ext` is 0 enters the waiting mode for the same 2^E cycles with `cpu_halt` 0. After the wait `clk_sel_ext` becomes 1. The request has no effect while `clk_sel_ext` is already 1.
- R8: During the waiting mode `sleep_req` and `clk_switch_req` are ignored. The wait length does not change and the controller ends in ACTIVE.
- R9: In ACTIVE a wake interrupt has no effect. When `sleep_req` and `clk_switch_req` arrive together, the sleep request wins and the clock selection is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | On-chip oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| sleep_req | input | 1 | One-cycle pulse from the sleep instruction |
| clk_switch_req | input | 1 | Software request to move to the external clock |
| wake_irq | input | IRQ_W | Enabled wake interrupts; any set bit wakes |
| cpu_halt | output | 1 | Stops the CPU |
| osc_en | output | 1 | Main oscillator enable |
| clk_sel_ext | output | 1 | 1 selects the main/external clock, 0 the on-chip clock |
| mode_o | output | 2 | Mode: 0 active, 1 sleep, 2 standby, 3 waiting |

## Verification
The assertions take for granted that `sleep_req` and `clk_switch_req` are single-cycle pulses. They also assume that `wake_irq` is a level the CPU side holds only briefly, so that one wake event is seen once. The stimulus drives every input on the falling edge and holds each request for exactly one cycle. It returns wake lines to zero before the next check, and it never issues a request in the cycle in which a register write that changes the mode bit lands.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE      = 3'd0,
        ST_SLEEP       = 3'd1,
        ST_STANDBY     = 3'd2,
        ST_WAIT_WAKE   = 3'd3,
        ST_WAIT_SWITCH = 3'd4
    } pmc_state_e;

    typedef enum logic [1:0] {
        MODE_ACTIVE  = 2'd0,
        MODE_SLEEP   = 2'd1,
        MODE_STANDBY = 2'd2,
        MODE_WAIT    = 2'd3
    } pmc_mode_e;

    localparam int CODE_W = 3;
    localparam int REG_W  = 8;

endpackage

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
    import pmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              standby_sel,
    output logic [CODE_W-1:0] wait_code
);

    localparam int SEL_BIT  = REG_W - 1;
    localparam int CODE_LSB = SEL_BIT - CODE_W;
    localparam int RSVD_W   = CODE_LSB;

    logic              sel_q;
    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            code_q <= '0;
        end else if (we) begin
            sel_q  <= wdata[SEL_BIT];
            code_q <= wdata[SEL_BIT-1:CODE_LSB];
        end
    end

    assign rdata       = {sel_q, code_q, {RSVD_W{1'b0}}};
    assign standby_sel = sel_q;
    assign wait_code   = code_q;

endmodule

// File: rtl/pmc_wait_timer.sv
module pmc_wait_timer
    import pmc_pkg::*;
#(
    parameter int MAX_EXP = 16,
    parameter int MIN_EXP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] code,
    output logic              done
);

    localparam int NCODES = 1 << CODE_W;
    localparam int CNT_W  = MAX_EXP;

    function automatic logic [CNT_W-1:0] last_of(input logic [CODE_W-1:0] c);
        int e;
        e = MAX_EXP - (int'(c) * (MAX_EXP - MIN_EXP)) / (NCODES - 1);
        return CNT_W'((64'd1 << e) - 64'd1);
    endfunction

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_q;
    logic             busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= '0;
            busy_q <= 1'b0;
        end else if (start) begin
            cnt_q  <= '0;
            last_q <= last_of(code);
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (cnt_q == last_q) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign done = busy_q && (cnt_q == last_q);

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sleep_req,
    input  logic      switch_req,
    input  logic      wake,
    input  logic      standby_sel,
    input  logic      timer_done,
    output logic      timer_start,
    output logic      cpu_halt,
    output logic      osc_en,
    output logic      clk_sel_ext,
    output pmc_mode_e mode
);

    pmc_state_e state_q, state_d;
    logic       sel_q, sel_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
            sel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (sleep_req) begin
                    if (standby_sel) begin
                        state_d = ST_STANDBY;
                        sel_d   = 1'b0;
                    end else begin
                        state_d = ST_SLEEP;
                    end
                end else if (switch_req && !sel_q) begin
                    state_d = ST_WAIT_SWITCH;
                end
            end
            ST_SLEEP: begin
                if (wake) state_d = ST_ACTIVE;
            end
            ST_STANDBY: begin
                if (wake) state_d = ST_WAIT_WAKE;
            end
            ST_WAIT_WAKE, ST_WAIT_SWITCH: begin
                if (timer_done) begin
                    state_d = ST_ACTIVE;
                    sel_d   = 1'b1;
                end
            end
            default: state_d = ST_ACTIVE;
        endcase
    end

    assign timer_start = (state_q != ST_WAIT_WAKE) && (state_q != ST_WAIT_SWITCH) &&
                         ((state_d == ST_WAIT_WAKE) || (state_d == ST_WAIT_SWITCH));

    always_comb begin
        cpu_halt    = 1'b0;
        osc_en      = 1'b1;
        clk_sel_ext = sel_q;
        mode        = MODE_ACTIVE;
        unique case (state_q)
            ST_ACTIVE: begin
                mode = MODE_ACTIVE;
            end
            ST_SLEEP: begin
                cpu_halt = 1'b1;
                mode     = MODE_SLEEP;
            end
            ST_STANDBY: begin
                cpu_halt    = 1'b1;
                osc_en      = 1'b0;
                clk_sel_ext = 1'b0;
                mode        = MODE_STANDBY;
            end
            ST_WAIT_WAKE: begin
                cpu_halt    = 1'b1;
                clk_sel_ext = 1'b0;
                mode        = MODE_WAIT;
            end
            ST_WAIT_SWITCH: begin
                clk_sel_ext = 1'b0;
                mode        = MODE_WAIT;
            end
            default: begin
                mode = MODE_ACTIVE;
            end
        endcase
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int IRQ_W   = 4,
    parameter int MAX_EXP = 16,
    parameter int MIN_EXP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             sleep_req,
    input  logic             clk_switch_req,
    input  logic [IRQ_W-1:0] wake_irq,
    output logic             cpu_halt,
    output logic             osc_en,
    output logic             clk_sel_ext,
    output logic [1:0]       mode_o
);

    logic              standby_sel;
    logic [CODE_W-1:0] wait_code;
    logic              timer_start;
    logic              timer_done;
    pmc_mode_e         mode;

    pmc_ctrl_reg u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (reg_we),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .standby_sel (standby_sel),
        .wait_code   (wait_code)
    );

    pmc_wait_timer #(
        .MAX_EXP (MAX_EXP),
        .MIN_EXP (MIN_EXP)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (timer_start),
        .code  (wait_code),
        .done  (timer_done)
    );

    pmc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .switch_req  (clk_switch_req),
        .wake        (|wake_irq),
        .standby_sel (standby_sel),
        .timer_done  (timer_done),
        .timer_start (timer_start),
        .cpu_halt    (cpu_halt),
        .osc_en      (osc_en),
        .clk_sel_ext (clk_sel_ext),
        .mode        (mode)
    );

    assign mode_o = mode;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
    parameter int IRQ_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       reg_rdata,
    input logic             sleep_req,
    input logic [IRQ_W-1:0] wake_irq,
    input logic             cpu_halt,
    input logic             osc_en,
    input logic             clk_sel_ext,
    input logic [1:0]       mode_o
);

    // R2: reserved bits never read back as one
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[3:0] == 4'h0);

    // R3: sleep keeps the oscillator and halts the CPU
    p_sleep_outputs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1) |-> (cpu_halt && osc_en));

    // R4: wake from sleep takes one cycle
    p_sleep_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1 && |wake_irq) |=> (mode_o == 2'd0));

    // R5: standby stops the oscillator and halts the CPU
    p_standby_outputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |-> (!osc_en && cpu_halt && !clk_sel_ext));

    // R6: internal clock and running oscillator during the wait
    p_wait_internal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd3) |-> (!clk_sel_ext && osc_en));

    // R7: main clock only selected right after a wait
    p_sel_after_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_sel_ext) |-> ($past(mode_o) == 2'd3));

    // R8: sleep request during the wait does not leave the wait early to sleep
    p_wait_no_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd3 && sleep_req) |=> (mode_o != 2'd1 && mode_o != 2'd2));

endmodule

bind pwr_mode_ctrl pmc_checker #(.IRQ_W(IRQ_W)) u_pmc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_rdata   (reg_rdata),
    .sleep_req   (sleep_req),
    .wake_irq    (wake_irq),
    .cpu_halt    (cpu_halt),
    .osc_en      (osc_en),
    .clk_sel_ext (clk_sel_ext),
    .mode_o      (mode_o)
);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;

    localparam int IRQ_W   = 4;
    localparam int MAX_EXP = 10;
    localparam int MIN_EXP = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0;
    logic [7:0]       reg_wdata = 8'h00;
    logic [7:0]       reg_rdata;
    logic             sleep_req = 1'b0;
    logic             clk_switch_req = 1'b0;
    logic [IRQ_W-1:0] wake_irq = '0;
    logic             cpu_halt, osc_en, clk_sel_ext;
    logic [1:0]       mode_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pwr_mode_ctrl #(.IRQ_W(IRQ_W), .MAX_EXP(MAX_EXP), .MIN_EXP(MIN_EXP)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sleep_req(sleep_req), .clk_switch_req(clk_switch_req),
        .wake_irq(wake_irq), .cpu_halt(cpu_halt), .osc_en(osc_en),
        .clk_sel_ext(clk_sel_ext), .mode_o(mode_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int wait_len(input int code);
        return 1 << (MAX_EXP - (code * (MAX_EXP - MIN_EXP)) / 7);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_reg(input logic [7:0] v);
        reg_we = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = 8'h00;
        @(negedge clk);
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
    endtask

    task automatic pulse_wake(input logic [IRQ_W-1:0] v);
        wake_irq = v; @(negedge clk); wake_irq = '0;
    endtask

    task automatic count_wait(input string req, input int exp_halt, output int n);
        n = 0;
        while (mode_o == 2'd3 && n < 5000) begin
            n++;
            if (cpu_halt !== exp_halt[0] || clk_sel_ext !== 1'b0 || osc_en !== 1'b1)
                check(req, {cpu_halt, clk_sel_ext, osc_en}, {exp_halt[0], 1'b0, 1'b1});
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 rdata", reg_rdata, 0);
        check("R1 mode", mode_o, 0);
        check("R1 outputs", {cpu_halt, osc_en, clk_sel_ext}, 3'b010);
    endtask

    task automatic t_register();
        do_reset();
        write_reg(8'hDF);
        check("R2 readback", reg_rdata, 8'hD0);
        write_reg(8'h2A);
        check("R2 readback2", reg_rdata, 8'h20);
    endtask

    task automatic t_switch(input int code);
        int n;
        do_reset();
        write_reg(8'(code << 4));
        clk_switch_req = 1'b1; @(negedge clk); clk_switch_req = 1'b0;
        check("R7 enters wait", mode_o, 3);
        count_wait("R7 wait outputs", 0, n);
        check("R7 wait length", n, wait_len(code));
        check("R7 sel after", clk_sel_ext, 1);
        clk_switch_req = 1'b1; @(negedge clk); clk_switch_req = 1'b0;
        check("R7 ignored when external", mode_o, 0);
    endtask

    task automatic t_sleep();
        do_reset();
        write_reg(8'h00);
        pulse_sleep();
        check("R3 mode sleep", mode_o, 1);
        check("R3 outputs", {cpu_halt, osc_en}, 2'b11);
        @(negedge clk);
        check("R3 holds", mode_o, 1);
        pulse_wake(4'b0100);
        check("R4 wake to active", mode_o, 0);
        check("R4 sel kept", clk_sel_ext, 0);
    endtask

    task automatic t_standby(input int code, input bit poke);
        int n;
        do_reset();
        write_reg(8'h80 | 8'(code << 4));
        pulse_sleep();
        check("R5 mode standby", mode_o, 2);
        check("R5 outputs", {cpu_halt, osc_en, clk_sel_ext}, 3'b100);
        repeat (3) @(negedge clk);
        check("R5 stays", mode_o, 2);
        pulse_wake(4'b0001);
        check("R6 enters wait", mode_o, 3);
        if (poke) begin
            sleep_req = 1'b1; clk_switch_req = 1'b1;
            @(negedge clk);
            sleep_req = 1'b0; clk_switch_req = 1'b0;
            count_wait("R8 wait outputs", 1, n);
            check("R8 wait length unchanged", n + 1, wait_len(code));
        end else begin
            count_wait("R6 wait outputs", 1, n);
            check("R6 wait length", n, wait_len(code));
        end
        check("R6 active after", mode_o, 0);
        check("R6 sel main", {clk_sel_ext, cpu_halt}, 2'b10);
    endtask

    task automatic t_priority();
        do_reset();
        pulse_wake(4'b1111);
        check("R9 wake in active", mode_o, 0);
        sleep_req = 1'b1; clk_switch_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0; clk_switch_req = 1'b0;
        check("R9 sleep wins", mode_o, 1);
        pulse_wake(4'b0010);
        check("R9 sel unchanged", {mode_o, clk_sel_ext}, 3'b000);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_register();
                t_switch(5);
                t_sleep();
                t_standby(7, 1'b0);
                t_standby(0, 1'b0);
                t_standby(3, 1'b1);
                t_priority();
            end
            begin
                repeat (50000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule